// File: doc/BRIEF.md
# Burst Memory Slave with AXI4 Channels

This block is a memory-mapped AXI4 slave that stores data in an internal register array. Its five channels are independent: write address, write data, write response, read address and read data. It accepts single bursts of FIXED, INCR and WRAP type, and it masks writes per byte with the write strobes. The slave tracks one write burst and one read burst at a time. Each has its own address sequencer, so a read and a write may proceed together.

A write burst starts with an address handshake. The slave then takes exactly AxLEN+1 data beats and returns one response. A read burst returns AxLEN+1 beats. Each read beat carries its own response, and the last beat is flagged. Illegal requests still run all of their beats but leave memory untouched, and so do beats that fall outside the array. Both report a slave error.

Top module: `axi_burst_mem`

## Requirements
- R1: After reset, awready_o and arready_o are 1 and bvalid_o and rvalid_o are 0. A transfer on any channel happens on a rising clock edge where its valid and ready are both 1.
- R2: Once bvalid_o or rvalid_o is 1, it stays 1 until the matching ready is seen on a clock edge. While it waits, bresp_o, bid_o, rdata_o, rresp_o, rid_o and rlast_o do not change.
- R3: wready_o stays 0 until a write address has been accepted. A burst has exactly len+1 beats (len = 8-bit AxLEN). One beat carries 2^size bytes (size = 3-bit AxSIZE), and at most 4 bytes.
- R4: Bit i of wstrb_i enables bits 8i+7..8i of wdata_i. A lane whose strobe is 0 keeps its old byte, and a beat with all strobes 0 writes nothing.
- R5: An INCR burst (code 2'b01) first uses the start address. Each later beat uses the previous address aligned down to 2^size, plus 2^size. INCR bursts of up to 256 beats are supported.
- R6: A FIXED burst (code 2'b00) uses the start address for every beat.
- R7: A WRAP burst (code 2'b10) steps like INCR inside a block of (len+1)*2^size bytes. The block is aligned to its own size. When the next address would leave the block, it wraps to the block's lowest address.
- R8: The write response is issued only after the last data beat has been accepted, and exactly once per burst. rlast_o is 1 on the final read beat and on no other beat.
- R9: A request is illegal if its burst code is 2'b11, its size exceeds 4 bytes, or it is a WRAP burst whose length is not 2, 4, 8 or 16. An illegal request still completes all of its beats. It writes no memory, it returns SLVERR (2'b10) on the write response, and it returns SLVERR with zero data on every read beat.
- R10: The memory spans byte addresses 0 to DEPTH*4-1. A beat addressed beyond this range is not written, and on a read it returns SLVERR with zero data. A write burst that has any such beat responds SLVERR. Every other access returns OKAY (2'b00), and EXOKAY (2'b01) is never returned.
- R11: bid_o equals the awid_i of the burst being answered, and rid_o equals its arid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| awid_i | input | ID_W | Write burst ID |
| awaddr_i | input | ADDR_W | Write start byte address |
| awlen_i | input | 8 | Write beats minus one |
| awsize_i | input | 3 | Write beat size, log2 bytes |
| awburst_i | input | 2 | Write burst type |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | DATA_W | Write data |
| wstrb_i | input | DATA_W/8 | Write byte enables |
| wlast_i | input | 1 | Last write beat marker |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bid_o | output | ID_W | Write response ID |
| bresp_o | output | 2 | Write response |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| arid_i | input | ID_W | Read burst ID |
| araddr_i | input | ADDR_W | Read start byte address |
| arlen_i | input | 8 | Read beats minus one |
| arsize_i | input | 3 | Read beat size, log2 bytes |
| arburst_i | input | 2 | Read burst type |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rid_o | output | ID_W | Read data ID |
| rdata_o | output | DATA_W | Read data |
| rresp_o | output | 2 | Per-beat read response |
| rlast_o | output | 1 | Last read beat |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |

## Verification
A wrong beat address in a sequencer shows up at the ports on the first read beat taken after that step. It appears as a swapped word in a read-back that the bench compares word by word, so a WRAP sweep over every start offset exposes a wrong wrap boundary within one burst. A miscounted beat counter shows up on the handshake that should have been the last. In that case bvalid_o rises a beat early or late, or rlast_o lands on the wrong beat. A lost error flag shows up as OKAY in the response of the same burst.

// File: rtl/axi_burst_mem_pkg.sv
package axi_burst_mem_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  function automatic logic req_legal(logic [1:0] burst, logic [7:0] len,
                                     logic [2:0] size, logic [2:0] max_size);
    logic ok;
    ok = (burst != BURST_RSVD) && (size <= max_size);
    if (burst == BURST_WRAP)
      ok = ok && (len == 8'd1 || len == 8'd3 || len == 8'd7 || len == 8'd15);
    return ok;
  endfunction
endpackage

// File: rtl/axi_burst_addr_step.sv
module axi_burst_addr_step
  import axi_burst_mem_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step, aligned, incr, wrap_mask;

  always_comb begin
    step      = ADDR_W'(1) << size_i;
    aligned   = addr_i & ~(step - ADDR_W'(1));
    incr      = aligned + step;
    wrap_mask = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
    case (burst_e'(burst_i))
      BURST_FIXED: next_o = addr_i;
      BURST_WRAP:  next_o = (addr_i & ~wrap_mask) | (incr & wrap_mask);
      default:     next_o = incr;
    endcase
  end
endmodule

// File: rtl/axi_burst_mem_array.sv
module axi_burst_mem_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wstrb_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
      end else if (we_i && wstrb_i[g]) begin
        lane_q[wr_idx_i] <= wdata_i[8*g +: 8];
      end
    end

    assign rd_data_o[8*g +: 8] = lane_q[rd_idx_i];
  end
endmodule

// File: rtl/axi_burst_wr_chan.sv
module axi_burst_wr_chan
  import axi_burst_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int MEM_BYTES = DEPTH * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   awid_i,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic [7:0]        awlen_i,
  input  logic [2:0]        awsize_i,
  input  logic [1:0]        awburst_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wstrb_i,
  input  logic              wlast_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [ID_W-1:0]   bid_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_wstrb_o
);
  typedef enum logic [1:0] {WS_IDLE, WS_DATA, WS_RESP} wstate_e;

  wstate_e           state_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ID_W-1:0]   id_q;
  logic              bad_q, err_q;
  logic              aw_hs, w_hs, b_hs, beat_ok, beat_last;

  assign awready_o = (state_q == WS_IDLE);
  assign wready_o  = (state_q == WS_DATA);
  assign bvalid_o  = (state_q == WS_RESP);
  assign bresp_o   = err_q ? RESP_SLVERR : RESP_OKAY;
  assign bid_o     = id_q;

  assign aw_hs     = awvalid_i && awready_o;
  assign w_hs      = wvalid_i && wready_o;
  assign b_hs      = bvalid_o && bready_i;
  assign beat_ok   = !bad_q && (addr_q < ADDR_W'(MEM_BYTES));
  assign beat_last = (cnt_q == len_q);

  assign mem_we_o    = w_hs && beat_ok;
  assign mem_idx_o   = addr_q[OFF_W +: IDX_W];
  assign mem_wdata_o = wdata_i;
  assign mem_wstrb_o = wstrb_i;

  axi_burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (addr_q),
    .len_i  (len_q),
    .size_i (size_q),
    .burst_i(burst_q),
    .next_o (addr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      id_q    <= '0;
      bad_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        WS_IDLE: if (aw_hs) begin
          addr_q  <= awaddr_i;
          len_q   <= awlen_i;
          size_q  <= awsize_i;
          burst_q <= awburst_i;
          id_q    <= awid_i;
          cnt_q   <= '0;
          bad_q   <= !req_legal(awburst_i, awlen_i, awsize_i, 3'(OFF_W));
          err_q   <= !req_legal(awburst_i, awlen_i, awsize_i, 3'(OFF_W));
          state_q <= WS_DATA;
        end
        WS_DATA: if (w_hs) begin
          err_q  <= err_q | !beat_ok;
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q + 8'd1;
          if (beat_last) state_q <= WS_RESP;
        end
        WS_RESP: if (b_hs) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  // R2
  bvalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o && $stable(bresp_o) && $stable(bid_o));
  // R8
  bresp_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bvalid_o) |-> $past(wvalid_i && wready_o && wlast_i));
  // R8
  wlast_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_hs |-> (wlast_i == beat_last));
  // R10
  no_exokay_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> (bresp_o != RESP_EXOKAY) && (bresp_o != RESP_DECERR));
  // R9
  bad_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !bad_q);
endmodule

// File: rtl/axi_burst_rd_chan.sv
module axi_burst_rd_chan
  import axi_burst_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int MEM_BYTES = DEPTH * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   arid_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic [7:0]        arlen_i,
  input  logic [2:0]        arsize_i,
  input  logic [1:0]        arburst_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [ID_W-1:0]   rid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rlast_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [IDX_W-1:0]  mem_idx_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt, ld_addr;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ID_W-1:0]   id_q;
  logic              bad_q, ld_bad, ld_ok;
  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        rresp_q;
  logic              rlast_q;
  logic              ar_hs, r_hs;

  assign arready_o = !busy_q;
  assign rvalid_o  = busy_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = rresp_q;
  assign rlast_o   = rlast_q;
  assign rid_o     = id_q;

  assign ar_hs = arvalid_i && arready_o;
  assign r_hs  = rvalid_o && rready_i;

  axi_burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (addr_q),
    .len_i  (len_q),
    .size_i (size_q),
    .burst_i(burst_q),
    .next_o (addr_nxt)
  );

  // Beat loaded at the address handshake or at each accepted beat.
  assign ld_addr   = busy_q ? addr_nxt : araddr_i;
  assign ld_bad    = busy_q ? bad_q : !req_legal(arburst_i, arlen_i, arsize_i, 3'(OFF_W));
  assign ld_ok     = !ld_bad && (ld_addr < ADDR_W'(MEM_BYTES));
  assign mem_idx_o = ld_addr[OFF_W +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      id_q    <= '0;
      bad_q   <= 1'b0;
      rdata_q <= '0;
      rresp_q <= RESP_OKAY;
      rlast_q <= 1'b0;
    end else if (ar_hs) begin
      busy_q  <= 1'b1;
      addr_q  <= araddr_i;
      len_q   <= arlen_i;
      size_q  <= arsize_i;
      burst_q <= arburst_i;
      id_q    <= arid_i;
      cnt_q   <= '0;
      bad_q   <= ld_bad;
      rdata_q <= ld_ok ? mem_rdata_i : '0;
      rresp_q <= ld_ok ? RESP_OKAY : RESP_SLVERR;
      rlast_q <= (arlen_i == 8'd0);
    end else if (r_hs) begin
      if (rlast_q) begin
        busy_q  <= 1'b0;
        rlast_q <= 1'b0;
      end else begin
        addr_q  <= addr_nxt;
        cnt_q   <= cnt_q + 8'd1;
        rdata_q <= ld_ok ? mem_rdata_i : '0;
        rresp_q <= ld_ok ? RESP_OKAY : RESP_SLVERR;
        rlast_q <= ((cnt_q + 8'd1) == len_q);
      end
    end
  end

  // R2
  rvalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o) && $stable(rresp_o)
                              && $stable(rlast_o) && $stable(rid_o));
  // R8
  rlast_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && rready_i && rlast_o |=> !rvalid_o);
  // R8
  rlast_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rlast_o == (cnt_q == len_q)));
  // R10
  no_exokay_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rresp_o != RESP_EXOKAY) && (rresp_o != RESP_DECERR));
  // R9
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && rresp_o == RESP_SLVERR |-> rdata_o == '0);
endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem
  import axi_burst_mem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   awid_i,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic [7:0]        awlen_i,
  input  logic [2:0]        awsize_i,
  input  logic [1:0]        awburst_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wstrb_i,
  input  logic              wlast_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [ID_W-1:0]   bid_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ID_W-1:0]   arid_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic [7:0]        arlen_i,
  input  logic [2:0]        arsize_i,
  input  logic [1:0]        arburst_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [ID_W-1:0]   rid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rlast_o,
  output logic              rvalid_o,
  input  logic              rready_i
);
  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx, mem_ridx;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [LANES-1:0]  mem_wstrb;

  axi_burst_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_wr (
    .clk_i, .rst_ni,
    .awid_i, .awaddr_i, .awlen_i, .awsize_i, .awburst_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wlast_i, .wvalid_i, .wready_o,
    .bid_o, .bresp_o, .bvalid_o, .bready_i,
    .mem_we_o   (mem_we),
    .mem_idx_o  (mem_widx),
    .mem_wdata_o(mem_wdata),
    .mem_wstrb_o(mem_wstrb)
  );

  axi_burst_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni,
    .arid_i, .araddr_i, .arlen_i, .arsize_i, .arburst_i, .arvalid_i, .arready_o,
    .rid_o, .rdata_o, .rresp_o, .rlast_o, .rvalid_o, .rready_i,
    .mem_idx_o  (mem_ridx),
    .mem_rdata_i(mem_rdata)
  );

  axi_burst_mem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .we_i     (mem_we),
    .wr_idx_i (mem_widx),
    .wdata_i  (mem_wdata),
    .wstrb_i  (mem_wstrb),
    .rd_idx_i (mem_ridx),
    .rd_data_o(mem_rdata)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> awready_o && arready_o && !bvalid_o && !rvalid_o);
  // R3
  wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> !awready_o && !bvalid_o);
endmodule

// File: tb/axi_burst_mem_test.sv
`timescale 1ns/1ps
module axi_burst_mem_test;
  localparam int MEMB = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  awid = '0, arid = '0;
  logic [31:0] awaddr = '0, araddr = '0;
  logic [7:0]  awlen = '0, arlen = '0;
  logic [2:0]  awsize = '0, arsize = '0;
  logic [1:0]  awburst = '0, arburst = '0;
  logic        awvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        wlast = 1'b0, wvalid = 1'b0, bready = 1'b0, rready = 1'b0;
  logic        awready, wready, bvalid, arready, rvalid, rlast;
  logic [3:0]  bid, rid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  model [MEMB];
  logic [31:0] wd [256];
  logic [3:0]  ws [256];

  always #4 clk = ~clk;

  axi_burst_mem uut (
    .clk_i(clk), .rst_ni(rst_n),
    .awid_i(awid), .awaddr_i(awaddr), .awlen_i(awlen), .awsize_i(awsize),
    .awburst_i(awburst), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wlast_i(wlast), .wvalid_i(wvalid), .wready_o(wready),
    .bid_o(bid), .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .arid_i(arid), .araddr_i(araddr), .arlen_i(arlen), .arsize_i(arsize),
    .arburst_i(arburst), .arvalid_i(arvalid), .arready_o(arready),
    .rid_o(rid), .rdata_o(rdata), .rresp_o(rresp), .rlast_o(rlast),
    .rvalid_o(rvalid), .rready_i(rready)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic legal(logic [1:0] b, logic [7:0] l, logic [2:0] s);
    if (b == 2'b11 || s > 3'd2) return 1'b0;
    if (b == 2'b10) return (l == 1 || l == 3 || l == 7 || l == 15);
    return 1'b1;
  endfunction

  function automatic int next_a(int a, int l, int s, logic [1:0] b);
    int bytes = 1 << s;
    int blk, base, n;
    if (b == 2'b00) return a;
    n = (a / bytes) * bytes + bytes;
    if (b == 2'b10) begin
      blk  = (l + 1) * bytes;
      base = (a / blk) * blk;
      if (n >= base + blk) n = base;
    end
    return n;
  endfunction

  function automatic logic [3:0] lane_strb(int a, int s);
    if (s == 0) return 4'b0001 << (a % 4);
    if (s == 1) return 4'b0011 << (a % 4 & 2);
    return 4'b1111;
  endfunction

  function automatic logic [31:0] model_word(int a);
    int w = (a / 4) * 4;
    return {model[w+3], model[w+2], model[w+1], model[w]};
  endfunction

  task automatic do_write(input int a0, input int l, input int s, input logic [1:0] b,
                          input logic [3:0] id, input int bdly, input string req);
    logic ok = legal(b, 8'(l), 3'(s));
    logic err = !ok;
    int a = a0;
    logic [1:0] b0;
    @(posedge clk); #1;
    awaddr = 32'(a0); awlen = 8'(l); awsize = 3'(s); awburst = b; awid = id; awvalid = 1'b1;
    forever begin @(negedge clk); if (awready) break; end
    @(posedge clk); #1 awvalid = 1'b0;
    for (int i = 0; i <= l; i++) begin
      wdata = wd[i]; wstrb = ws[i]; wlast = (i == l); wvalid = 1'b1;
      forever begin
        @(negedge clk);
        check(!bvalid, "R8 bvalid before last beat", bvalid, 0);
        if (wready) break;
      end
      if (ok && a < MEMB)
        for (int k = 0; k < 4; k++)
          if (ws[i][k]) model[(a / 4) * 4 + k] = wd[i][8*k +: 8];
      if (a >= MEMB) err = 1'b1;
      a = next_a(a, l, s, b);
      @(posedge clk); #1;
    end
    wvalid = 1'b0; wlast = 1'b0;
    forever begin @(negedge clk); if (bvalid) break; end
    b0 = bresp;
    for (int k = 0; k < bdly; k++) begin
      @(negedge clk);
      check(bvalid && bresp == b0, "R2 bvalid/bresp held", {bvalid, bresp}, {1'b1, b0});
    end
    check(bresp == (err ? 2'b10 : 2'b00), {req, " bresp"}, bresp, err ? 2 : 0);
    check(bid == id, "R11 bid", bid, id);
    bready = 1'b1;
    @(posedge clk); #1 bready = 1'b0;
    @(negedge clk);
    check(!bvalid, "R8 single write response", bvalid, 0);
  endtask

  task automatic do_read(input int a0, input int l, input int s, input logic [1:0] b,
                         input logic [3:0] id, input int rdly, input string req);
    logic ok = legal(b, 8'(l), 3'(s));
    int a = a0;
    logic [31:0] d0;
    logic [31:0] expd;
    logic [1:0]  expr;
    @(posedge clk); #1;
    araddr = 32'(a0); arlen = 8'(l); arsize = 3'(s); arburst = b; arid = id; arvalid = 1'b1;
    forever begin @(negedge clk); if (arready) break; end
    @(posedge clk); #1 arvalid = 1'b0;
    for (int i = 0; i <= l; i++) begin
      forever begin @(negedge clk); if (rvalid) break; end
      d0 = rdata;
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        check(rvalid && rdata == d0, "R2 rvalid/rdata held", rdata, d0);
      end
      if (ok && a < MEMB) begin expd = model_word(a); expr = 2'b00; end
      else begin expd = '0; expr = 2'b10; end
      check(rdata == expd, {req, " rdata"}, rdata, expd);
      check(rresp == expr, {req, " rresp"}, rresp, expr);
      check(rlast == (i == l), "R8 rlast", rlast, i == l);
      check(rid == id, "R11 rid", rid, id);
      rready = 1'b1;
      @(posedge clk); #1 rready = 1'b0;
      a = next_a(a, l, s, b);
    end
    @(negedge clk);
    check(!rvalid, "R8 read ends after last", rvalid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMB; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(awready && arready && !bvalid && !rvalid, "R1 reset state",
          {awready, arready, bvalid, rvalid}, 4'b1100);

    // R3: data presented before the address is not taken
    wvalid = 1'b1; wdata = 32'hDEAD_BEEF; wstrb = 4'hF;
    repeat (3) begin @(negedge clk); check(!wready, "R3 wready before address", wready, 0); end
    wvalid = 1'b0;

    // R5 R1: INCR full words
    for (int i = 0; i < 4; i++) begin wd[i] = 32'h1111_1111 * (i + 1); ws[i] = 4'hF; end
    do_write(32'h10, 3, 2, 2'b01, 4'h3, 2, "R5 incr write");
    do_read(32'h10, 3, 2, 2'b01, 4'h5, 1, "R5 incr read");

    // R4: partial and empty strobes
    wd[0] = 32'hAABB_CCDD; ws[0] = 4'b0101;
    wd[1] = 32'hFFFF_FFFF; ws[1] = 4'b0000;
    do_write(32'h14, 1, 2, 2'b01, 4'h1, 0, "R4 strobe write");
    do_read(32'h10, 3, 2, 2'b01, 4'h2, 0, "R4 strobe read");

    // R6: FIXED accumulates lanes at one address
    wd[0] = 32'h0000_0011; ws[0] = 4'b0001;
    wd[1] = 32'h0000_2200; ws[1] = 4'b0010;
    wd[2] = 32'h3300_0000; ws[2] = 4'b1000;
    do_write(32'h40, 2, 2, 2'b00, 4'h7, 3, "R6 fixed write");
    do_read(32'h40, 1, 2, 2'b00, 4'h8, 2, "R6 fixed read");

    // R7: WRAP over every length and start word
    for (int lg = 1; lg <= 4; lg++) begin
      int n = 1 << lg;
      for (int st = 0; st < n; st++) begin
        for (int i = 0; i < n; i++) begin wd[i] = {8'(n), 8'(st), 16'(i) ^ 16'hA5C3}; ws[i] = 4'hF; end
        do_write(32'h80 + st * 4, n - 1, 2, 2'b10, 4'(st), 0, "R7 wrap write");
        do_read(32'h80, n - 1, 2, 2'b01, 4'(n), 0, "R7 wrap readback");
      end
    end
    // R7: halfword wrap
    for (int i = 0; i < 4; i++) begin
      wd[i] = 32'h1234_5678 + 32'(i) * 32'h0101_0101;
      ws[i] = lane_strb(next_a(next_a(next_a(32'hC6, 3, 1, 2'b10), 3, 1, 2'b10), 3, 1, 2'b10), 1);
    end
    begin
      int a = 32'hC6;
      for (int i = 0; i < 4; i++) begin ws[i] = lane_strb(a, 1); a = next_a(a, 3, 1, 2'b10); end
    end
    do_write(32'hC6, 3, 1, 2'b10, 4'h9, 0, "R7 halfword wrap write");
    do_read(32'hC0, 1, 2, 2'b01, 4'hA, 0, "R7 halfword wrap read");
    do_read(32'hC6, 3, 1, 2'b10, 4'hB, 0, "R7 halfword wrap read");

    // R9: illegal requests
    for (int i = 0; i < 4; i++) begin wd[i] = 32'hBAD0_0000 + 32'(i); ws[i] = 4'hF; end
    do_write(32'h80, 2, 2, 2'b10, 4'h2, 1, "R9 wrap len 3 write");
    do_read(32'h80, 2, 2, 2'b10, 4'h2, 1, "R9 wrap len 3 read");
    do_write(32'h80, 1, 2, 2'b11, 4'h4, 0, "R9 reserved burst write");
    do_read(32'h80, 1, 2, 2'b11, 4'h4, 0, "R9 reserved burst read");
    do_write(32'h80, 0, 3, 2'b01, 4'h6, 0, "R9 oversize write");
    do_read(32'h80, 0, 3, 2'b01, 4'h6, 0, "R9 oversize read");
    do_read(32'h80, 3, 2, 2'b01, 4'h0, 0, "R9 memory unchanged");

    // R10: INCR running past the top
    for (int i = 0; i < 4; i++) begin wd[i] = 32'h7070_0000 + 32'(i); ws[i] = 4'hF; end
    do_write(32'hF8, 3, 2, 2'b01, 4'hC, 0, "R10 edge write");
    do_read(32'hF8, 3, 2, 2'b01, 4'hD, 0, "R10 edge read");
    do_read(32'h400, 0, 2, 2'b00, 4'hE, 0, "R10 far read");

    // R5: 256-beat byte INCR across the whole array
    for (int i = 0; i < 256; i++) begin
      wd[i] = {4{8'(i) ^ 8'h5A}};
      ws[i] = lane_strb(i, 0);
    end
    do_write(32'h0, 255, 0, 2'b01, 4'hF, 1, "R5 256-beat write");
    do_read(32'h0, 63, 2, 2'b01, 4'h1, 0, "R5 word readback");
    do_read(32'h0, 255, 0, 2'b01, 4'h3, 0, "R5 256-beat byte read");

    // R3 R5: halfword INCR
    begin
      int a = 32'h62;
      for (int i = 0; i < 8; i++) begin
        wd[i] = 32'hC0DE_0000 | 32'(i * 257); ws[i] = lane_strb(a, 1); a = next_a(a, 7, 1, 2'b01);
      end
    end
    do_write(32'h62, 7, 1, 2'b01, 4'h5, 0, "R3 halfword incr write");
    do_read(32'h60, 4, 2, 2'b01, 4'h5, 0, "R3 halfword incr read");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule